// File: doc/BRIEF.md
# Strip-Module Serial Event Decoder

This block watches a single serial line, one bit per clock, that carries framed events from a silicon strip readout module. While the line is idle it searches for the event start pattern. After the start pattern it extracts the level-1 and bunch-crossing identifiers. It then walks through the packets that follow and reports every hit as a chip number, a channel number and three crossing bits. Short cluster packets, which carry only crossing bits, are expanded into full channel numbers from the hit before them.

Each recovered item leaves as a one-cycle pulse with its fields. These items are the identifier announcement, a hit, a chip with no hits, and the end of an event. The identifiers of the current event stay on their outputs until the next event replaces them. Any break in the framing raises a one-cycle error pulse, and the decoder then returns to searching for the next event start.

Top module: `strip_evt_decoder`

## Requirements
- R1: While searching, the decoder produces no output pulse until the six most recent bits, oldest first, read 1,1,1,0,1,0. Searching starts after reset, after an end of event and after any framing error, each time with an empty bit history.
- R2: After the start pattern, the next 4 bits are the level-1 identifier and the 8 bits after them are the crossing identifier, both most significant bit first. A sync bit of 1 follows. In the cycle after that sync bit, `hdr_valid` pulses for one cycle and `evt_l1id`/`evt_bcid` take the new values. These outputs hold their values until the next accepted start.
- R3: At a packet boundary, the bits 0,1 begin a full hit. A full hit carries 4 chip bits, then 7 channel bits, then a sync 1, then 3 crossing bits, every field most significant bit first. In the cycle after the last crossing bit, `hit_valid` pulses with those fields and `hit_clus` is 0.
- R4: Straight after the crossing bits of a hit or cluster, a 1 starts a cluster of 3 crossing bits. The cluster is reported with the same chip, the previous channel plus one (modulo 128) and `hit_clus` set to 1. A 0 in that position instead returns the decoder to a packet boundary.
- R5: At a packet boundary, the bits 0,0,1 are a no-hit packet. In the cycle after its last bit `nohit_valid` pulses, no hit is reported, and the decoder is again at a packet boundary.
- R6: At a packet boundary, a 1 followed by 15 zeros ends the event. `evt_done` pulses in the cycle after the fifteenth zero, and searching resumes.
- R7: Any of the following raises `frame_err` for one cycle, in the cycle after the offending bit, and returns the decoder to searching: a 0 in the identifier sync position, a 0 in the hit sync position, a third 0 at a packet boundary, or a 1 among the 15 trailer zeros.
- R8: During and straight after reset every pulse output is 0, and the identifier and hit field outputs are 0.
- R9: At most one of `hdr_valid`, `hit_valid`, `nohit_valid`, `evt_done` and `frame_err` is high in any cycle. A hit pulse is never followed by a hit pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one line bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial event line |
| hdr_valid | output | 1 | Identifiers of a new event accepted |
| evt_l1id | output | 4 | Level-1 identifier of the current event |
| evt_bcid | output | 8 | Crossing identifier of the current event |
| hit_valid | output | 1 | Hit record present |
| hit_chip | output | 4 | Chip number of the hit |
| hit_chan | output | 7 | Channel number of the hit |
| hit_bx | output | 3 | Crossing bits of the hit |
| hit_clus | output | 1 | Hit came from a cluster continuation |
| nohit_valid | output | 1 | No-hit packet seen |
| evt_done | output | 1 | Trailer completed |
| frame_err | output | 1 | Framing error; decoder resumes searching |

## Verification
The hardest condition to reach is a cluster run that crosses channel 127, because the channel wraps to 0 while the chip stays the same. The stimulus reaches it with a full hit on channel 126 followed by several cluster continuations. A further hard case is a trailer whose run of zeros is broken by a 1 in its last position. A third is a no-hit packet placed straight after a hit, where the separator zero and the packet's own zeros must not be counted together. Each is built as a directed bit sequence. Randomised events mixing hits, cluster runs, no-hit packets and noisy idle gaps are then run past a bit-by-bit reference parser that checks every output on every clock.

// File: rtl/strip_evt_decoder.sv
module strip_evt_decoder #(
  parameter int L1W    = 4,
  parameter int BCW    = 8,
  parameter int CHIPW  = 4,
  parameter int CHANW  = 7,
  parameter int BXW    = 3,
  parameter int TRAILZ = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  output logic             hdr_valid,
  output logic [L1W-1:0]   evt_l1id,
  output logic [BCW-1:0]   evt_bcid,
  output logic             hit_valid,
  output logic [CHIPW-1:0] hit_chip,
  output logic [CHANW-1:0] hit_chan,
  output logic [BXW-1:0]   hit_bx,
  output logic             hit_clus,
  output logic             nohit_valid,
  output logic             evt_done,
  output logic             frame_err
);
  localparam logic [5:0] START = 6'b111010;
  localparam int F1   = (L1W > BCW) ? L1W : BCW;
  localparam int F2   = (CHIPW > CHANW) ? CHIPW : CHANW;
  localparam int FMAX = (F1 > F2) ? F1 : F2;
  localparam int AW   = (FMAX > BXW) ? FMAX : BXW;
  localparam int CMAX = (TRAILZ > AW) ? TRAILZ : AW;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [3:0] {
    S_HUNT, S_L1, S_BC, S_HSYNC, S_PKT, S_CHIP, S_CHAN,
    S_DSYNC, S_BX, S_AFTER, S_CLBX, S_TRAIL
  } st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   acc;
  logic [5:0]      hist;
  logic [L1W-1:0]  l1_q;
  logic [BCW-1:0]  bc_q;
  logic [CHIPW-1:0] chip_q;
  logic [CHANW-1:0] chan_q;

  wire [AW-1:0] acc_nx  = {acc[AW-2:0], ser_in};
  wire          last    = (cnt == '0);
  wire [CW-1:0] cnt_dec = cnt - CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_HUNT; cnt <= '0; acc <= '0; hist <= '0;
      l1_q <= '0; bc_q <= '0; chip_q <= '0; chan_q <= '0;
      hdr_valid <= 1'b0; evt_l1id <= '0; evt_bcid <= '0;
      hit_valid <= 1'b0; hit_chip <= '0; hit_chan <= '0; hit_bx <= '0; hit_clus <= 1'b0;
      nohit_valid <= 1'b0; evt_done <= 1'b0; frame_err <= 1'b0;
    end else begin
      hdr_valid <= 1'b0; hit_valid <= 1'b0; nohit_valid <= 1'b0;
      evt_done <= 1'b0; frame_err <= 1'b0;
      acc <= acc_nx;
      case (st)
        S_HUNT: begin
          hist <= {hist[4:0], ser_in};
          if ({hist[4:0], ser_in} == START) begin
            st <= S_L1; cnt <= CW'(L1W - 1);
          end
        end
        S_L1: if (last) begin
          l1_q <= acc_nx[L1W-1:0]; st <= S_BC; cnt <= CW'(BCW - 1);
        end else cnt <= cnt_dec;
        S_BC: if (last) begin
          bc_q <= acc_nx[BCW-1:0]; st <= S_HSYNC;
        end else cnt <= cnt_dec;
        S_HSYNC: if (ser_in) begin
          hdr_valid <= 1'b1; evt_l1id <= l1_q; evt_bcid <= bc_q;
          st <= S_PKT; cnt <= '0;
        end else begin
          frame_err <= 1'b1; st <= S_HUNT; hist <= '0;
        end
        S_PKT: if (ser_in) begin
          if (cnt == CW'(0)) begin
            st <= S_TRAIL; cnt <= '0;
          end else if (cnt == CW'(1)) begin
            st <= S_CHIP; cnt <= CW'(CHIPW - 1);
          end else begin
            nohit_valid <= 1'b1; cnt <= '0;
          end
        end else if (cnt == CW'(2)) begin
          frame_err <= 1'b1; st <= S_HUNT; hist <= '0;
        end else cnt <= cnt + CW'(1);
        S_CHIP: if (last) begin
          chip_q <= acc_nx[CHIPW-1:0]; st <= S_CHAN; cnt <= CW'(CHANW - 1);
        end else cnt <= cnt_dec;
        S_CHAN: if (last) begin
          chan_q <= acc_nx[CHANW-1:0]; st <= S_DSYNC;
        end else cnt <= cnt_dec;
        S_DSYNC: if (ser_in) begin
          st <= S_BX; cnt <= CW'(BXW - 1);
        end else begin
          frame_err <= 1'b1; st <= S_HUNT; hist <= '0;
        end
        S_BX: if (last) begin
          hit_valid <= 1'b1; hit_clus <= 1'b0; hit_chip <= chip_q;
          hit_chan <= chan_q; hit_bx <= acc_nx[BXW-1:0]; st <= S_AFTER;
        end else cnt <= cnt_dec;
        S_AFTER: if (ser_in) begin
          st <= S_CLBX; cnt <= CW'(BXW - 1); chan_q <= chan_q + CHANW'(1);
        end else begin
          st <= S_PKT; cnt <= '0;
        end
        S_CLBX: if (last) begin
          hit_valid <= 1'b1; hit_clus <= 1'b1; hit_chip <= chip_q;
          hit_chan <= chan_q; hit_bx <= acc_nx[BXW-1:0]; st <= S_AFTER;
        end else cnt <= cnt_dec;
        S_TRAIL: if (ser_in) begin
          frame_err <= 1'b1; st <= S_HUNT; hist <= '0;
        end else if (cnt == CW'(TRAILZ - 1)) begin
          evt_done <= 1'b1; st <= S_HUNT; hist <= '0;
        end else cnt <= cnt + CW'(1);
        default: begin
          st <= S_HUNT; hist <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/strip_evt_decoder_chk.sv
module strip_evt_decoder_chk #(
  parameter int L1W   = 4,
  parameter int CHIPW = 4,
  parameter int CHANW = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic [L1W-1:0]   evt_l1id,
  input logic             hit_valid,
  input logic [CHIPW-1:0] hit_chip,
  input logic [CHANW-1:0] hit_chan,
  input logic             hit_clus,
  input logic             nohit_valid,
  input logic             evt_done,
  input logic             frame_err
);
  logic [CHIPW-1:0] seen_chip;
  logic [CHANW-1:0] seen_chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_chip <= '0; seen_chan <= '0;
    end else if (hit_valid) begin
      seen_chip <= hit_chip; seen_chan <= hit_chan;
    end
  end

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_valid, hit_valid, nohit_valid, evt_done, frame_err})); // R9
  AST_HIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |=> !hit_valid); // R9
  AST_CLUSTER_NEXT_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_clus) |-> (hit_chan == CHANW'(seen_chan + CHANW'(1)) && hit_chip == seen_chip)); // R4
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R7
  AST_DONE_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !(hit_valid || nohit_valid || hdr_valid)); // R6
  AST_IDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |-> $stable(evt_l1id)); // R2
endmodule

bind strip_evt_decoder strip_evt_decoder_chk #(.L1W(L1W), .CHIPW(CHIPW), .CHANW(CHANW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .evt_l1id(evt_l1id),
  .hit_valid(hit_valid), .hit_chip(hit_chip), .hit_chan(hit_chan), .hit_clus(hit_clus),
  .nohit_valid(nohit_valid), .evt_done(evt_done), .frame_err(frame_err)
);

// File: tb/strip_evt_decoder_test.sv
module strip_evt_decoder_test;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0, ser_in = 1'b0;
  logic hdr_valid, hit_valid, hit_clus, nohit_valid, evt_done, frame_err;
  logic [3:0] evt_l1id, hit_chip;
  logic [7:0] evt_bcid;
  logic [6:0] hit_chan;
  logic [2:0] hit_bx;

  strip_evt_decoder uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .hdr_valid(hdr_valid),
    .evt_l1id(evt_l1id), .evt_bcid(evt_bcid), .hit_valid(hit_valid),
    .hit_chip(hit_chip), .hit_chan(hit_chan), .hit_bx(hit_bx), .hit_clus(hit_clus),
    .nohit_valid(nohit_valid), .evt_done(evt_done), .frame_err(frame_err));

  always #(PER/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int stim[$];

  // reference parser state
  int mode = 0, hist = 0, zeros = 0, m_chip = 0, m_chan = 0;
  int q[$];
  int e_hdr, e_l1 = 0, e_bc = 0, e_hit, e_chip, e_chan, e_bx, e_clus, e_nohit, e_done, e_err;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push_bits(int v, int w);
    for (int i = w - 1; i >= 0; i--) stim.push_back((v >> i) & 1);
  endtask
  task automatic push_hdr(int l1, int bc);
    push_bits(6'b111010, 6); push_bits(l1, 4); push_bits(bc, 8); push_bits(1, 1);
  endtask
  task automatic push_hit(int chip, int chan, int bx);
    push_bits(1, 2); push_bits(chip, 4); push_bits(chan, 7); push_bits(1, 1); push_bits(bx, 3);
  endtask
  task automatic push_clus(int bx); push_bits(1, 1); push_bits(bx, 3); endtask
  task automatic push_sep(); push_bits(0, 1); endtask
  task automatic push_nohit(); push_bits(1, 3); endtask
  task automatic push_trailer(); push_bits(1, 1); push_bits(0, 15); endtask

  task automatic go_hunt(); mode = 0; hist = 0; e_err = 1; endtask

  task automatic model(int b);
    e_hdr = 0; e_hit = 0; e_nohit = 0; e_done = 0; e_err = 0;
    case (mode)
      0: begin
        hist = ((hist << 1) | b) & 63;
        if (hist == 58) begin mode = 1; q.delete(); end
      end
      1: begin
        q.push_back(b);
        if (q.size() == 13) begin
          if (q[12] == 1) begin
            e_l1 = 0; e_bc = 0;
            for (int i = 0; i < 4; i++) e_l1 = e_l1 * 2 + q[i];
            for (int i = 4; i < 12; i++) e_bc = e_bc * 2 + q[i];
            e_hdr = 1; mode = 2; zeros = 0;
          end else go_hunt();
        end
      end
      2: begin
        if (b == 1) begin
          if (zeros == 0) begin mode = 6; zeros = 0; end
          else if (zeros == 1) begin mode = 3; q.delete(); end
          else begin e_nohit = 1; zeros = 0; end
        end else if (zeros == 2) go_hunt();
        else zeros++;
      end
      3: begin
        q.push_back(b);
        if (q.size() == 12 && b == 0) go_hunt();
        else if (q.size() == 15) begin
          m_chip = 0; m_chan = 0; e_bx = 0;
          for (int i = 0; i < 4; i++) m_chip = m_chip * 2 + q[i];
          for (int i = 4; i < 11; i++) m_chan = m_chan * 2 + q[i];
          for (int i = 12; i < 15; i++) e_bx = e_bx * 2 + q[i];
          e_hit = 1; e_clus = 0; e_chip = m_chip; e_chan = m_chan; mode = 4;
        end
      end
      4: begin
        if (b == 1) begin mode = 5; q.delete(); end
        else begin mode = 2; zeros = 0; end
      end
      5: begin
        q.push_back(b);
        if (q.size() == 3) begin
          m_chan = (m_chan + 1) % 128;
          e_bx = q[0] * 4 + q[1] * 2 + q[2];
          e_hit = 1; e_clus = 1; e_chip = m_chip; e_chan = m_chan; mode = 4;
        end
      end
      default: begin
        if (b == 1) go_hunt();
        else begin
          zeros++;
          if (zeros == 15) begin e_done = 1; mode = 0; hist = 0; end
        end
      end
    endcase
  endtask

  task automatic compare_all();
    chk("R1/R2", "hdr_valid", hdr_valid, e_hdr);
    chk("R2", "evt_l1id", evt_l1id, e_l1);
    chk("R2", "evt_bcid", evt_bcid, e_bc);
    chk("R3", "hit_valid", hit_valid, e_hit);
    if (e_hit && hit_valid) begin
      chk(e_clus ? "R4" : "R3", "hit_chip", hit_chip, e_chip);
      chk(e_clus ? "R4" : "R3", "hit_chan", hit_chan, e_chan);
      chk(e_clus ? "R4" : "R3", "hit_bx", hit_bx, e_bx);
      chk(e_clus ? "R4" : "R3", "hit_clus", hit_clus, e_clus);
    end
    chk("R5", "nohit_valid", nohit_valid, e_nohit);
    chk("R6", "evt_done", evt_done, e_done);
    chk("R7", "frame_err", frame_err, e_err);
    chk("R9", "pulse count", int'(hdr_valid) + int'(hit_valid) + int'(nohit_valid)
        + int'(evt_done) + int'(frame_err), e_hdr + e_hit + e_nohit + e_done + e_err);
  endtask

  task automatic run_stim();
    while (stim.size() > 0) begin
      int b = stim.pop_front();
      ser_in = b[0];
      model(b);
      @(posedge clk);
      #(PER/4);
      compare_all();
    end
  endtask

  task automatic rand_event();
    int nchips = $urandom_range(1, 4);
    push_hdr($urandom_range(0, 15), $urandom_range(0, 255));
    for (int c = 0; c < nchips; c++) begin
      if ($urandom_range(0, 2) == 0) push_nohit();
      else begin
        push_hit($urandom_range(0, 15), $urandom_range(0, 127), $urandom_range(0, 7));
        for (int k = $urandom_range(0, 3); k > 0; k--) push_clus($urandom_range(0, 7));
        push_sep();
      end
    end
    push_trailer();
    for (int i = $urandom_range(0, 12); i > 0; i--) stim.push_back($urandom_range(0, 1));
    for (int i = 0; i < 6; i++) stim.push_back(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PER/4);
    // R8: reset values
    chk("R8", "hdr_valid", hdr_valid, 0); chk("R8", "hit_valid", hit_valid, 0);
    chk("R8", "evt_l1id", evt_l1id, 0);   chk("R8", "hit_chan", hit_chan, 0);
    chk("R8", "frame_err", frame_err, 0); chk("R8", "evt_done", evt_done, 0);
    rst_n = 1'b1;
    @(posedge clk); #(PER/4);
    chk("R8", "nohit_valid after reset", nohit_valid, 0);
    e_hdr = 0; e_hit = 0; e_nohit = 0; e_done = 0; e_err = 0;

    // R1: idle noise with near-miss start patterns
    push_bits(16'b1110_1100_1110_1110, 16); push_bits(0, 4);
    // R3 R4 R5 R6: full event, cluster run crossing channel 127
    push_hdr(4'hA, 8'hC5);
    push_hit(3, 126, 5); push_clus(2); push_clus(7); push_clus(1); push_sep();
    push_nohit();
    push_hit(15, 0, 0); push_sep(); push_nohit();
    push_trailer();
    push_bits(0, 5);
    // R2: second event replaces ids, empty chips only
    push_hdr(4'h3, 8'h0F); push_nohit(); push_nohit(); push_trailer();
    // R7: header sync zero
    push_bits(6'b111010, 6); push_bits(9, 4); push_bits(77, 8); push_bits(0, 1);
    push_bits(0, 3);
    // R7: hit sync zero
    push_hdr(1, 2); push_bits(1, 2); push_bits(4, 4); push_bits(9, 7); push_bits(0, 1);
    push_bits(0, 3);
    // R7: three zeros at a packet boundary
    push_hdr(2, 3); push_bits(0, 3); push_bits(0, 2);
    // R7: one in the last trailer position
    push_hdr(5, 6); push_nohit(); push_bits(1, 1); push_bits(0, 14); push_bits(1, 1);
    // start pattern straight after an error
    push_hdr(7, 200); push_hit(1, 1, 1); push_sep(); push_trailer();
    run_stim();
    // randomised events
    for (int n = 0; n < 40; n++) rand_event();
    run_stim();
    repeat (4) begin stim.push_back(0); end
    run_stim();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule